// File: doc/BRIEF.md
# PHY Event Source Flag Register

This block gathers seven event indications coming from an Ethernet PHY and keeps them as sticky flags in one 16-bit read-only register. Two of the inputs are status levels: energy present and link up. Each of these raises its flag only on one particular transition. The other five inputs are single-cycle event pulses, and each raises its flag directly. A flag can be raised only while its bit in the mask input is set.

Software learns which events have occurred by reading the register through a simple strobe-and-index read port. That read also clears every flag. A single registered interrupt request line stays high while any flag is set.

An event that arrives in the same cycle as the clearing read is never lost: the read returns the old contents, and the new flag remains set afterwards.

Top module: `phy_irq_src_latch`

## Requirements
- R1: When `rd_stb_i` is high and `rd_idx_i` equals 29, `rd_data_o` presents the flag register in that same cycle.
- R2: Bits 15:8 and bit 0 of the read data are always 0, whatever the mask and inputs.
- R3: Flag bit positions: 7 = energy became present, 6 = auto-negotiation done, 5 = remote fault, 4 = link went down, 3 = link-partner acknowledge, 2 = parallel-detection fault, 1 = page received.
- R4: Energy sets bit 7 only on a 0-to-1 change, and link sets bit 4 only on a 1-to-0 change. Both previous-value registers reset to 0, and a held level raises nothing again after a clear.
- R5: A set flag stays set until a clearing read, whatever the event inputs or the mask do in the meantime.
- R6: A read of index 29 clears all flags at the clock edge that ends the read cycle.
- R7: An event whose mask bit (the same bit position as its flag) is 0 is discarded, and does not appear when the mask is set later.
- R8: An event in the same cycle as a clearing read does not appear in that read, and its flag is set after the read.
- R9: A read of any index other than 29 returns 0 and leaves the flags unchanged.
- R10: `irq_o` is the OR of flag bits 7:1, registered, so it follows the flags one cycle later.
- R11: After reset, all flags and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| energy_on_i | input | 1 | Energy-present status level |
| an_done_i | input | 1 | Auto-negotiation complete pulse |
| rem_fault_i | input | 1 | Remote fault pulse |
| link_up_i | input | 1 | Link status level |
| lp_ack_i | input | 1 | Link-partner acknowledge pulse |
| pd_fault_i | input | 1 | Parallel-detection fault pulse |
| page_rx_i | input | 1 | Page received pulse |
| mask_i | input | 16 | Per-bit event enable |
| rd_stb_i | input | 1 | Register read strobe |
| rd_idx_i | input | 5 | Register index of the read |
| rd_data_o | output | 16 | Read data, 0 unless the flag register is selected |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to create from the ports is an event that lands in the very cycle a clearing read is in progress. The bench handles it by holding the read strobe and raising a pulse input in the same cycle. It then checks that the read value excludes the new event and that a second read shows it.

The level inputs also need care, because only one transition direction may count. The bench walks each level through both directions, holds it across a clear, and confirms that only the intended edge is recorded.

A sweep over all 128 mask patterns fires every source at once. While doing so it sets the reserved mask bits, which shows that they never reach the read data.

// File: rtl/phy_irq_pkg.sv
`timescale 1ns/1ps
package phy_irq_pkg;

   localparam int NUM_SRC = 7;

   typedef enum logic [1:0] {
      EV_PULSE = 2'd0,
      EV_RISE  = 2'd1,
      EV_FALL  = 2'd2
   } ev_kind_e;

   // Source index i lands on register bit (SRC_LSB + i).
   // 0 page rx, 1 pd fault, 2 lp ack, 3 link down, 4 remote fault, 5 an done, 6 energy
   function automatic ev_kind_e src_kind(input int idx);
      case (idx)
         3:       return EV_FALL;
         6:       return EV_RISE;
         default: return EV_PULSE;
      endcase
   endfunction

endpackage

// File: rtl/phy_irq_evdet.sv
`timescale 1ns/1ps
module phy_irq_evdet
   import phy_irq_pkg::*;
#(
   parameter ev_kind_e KIND = EV_PULSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic event_o
);

   localparam logic USE_PULSE = (KIND == EV_PULSE);
   localparam logic USE_RISE  = (KIND == EV_RISE);
   localparam logic USE_FALL  = (KIND == EV_FALL);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i;
   end

   assign event_o = (USE_PULSE & sig_i)
                  | (USE_RISE  & sig_i & ~prev_q)
                  | (USE_FALL  & ~sig_i & prev_q);

endmodule

// File: rtl/phy_irq_flag.sv
`timescale 1ns/1ps
module phy_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o && !clr_i |=> flag_o);

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !set_i |=> !flag_o);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

endmodule

// File: rtl/phy_irq_src_latch.sv
`timescale 1ns/1ps
module phy_irq_src_latch
   import phy_irq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 5,
   parameter int REG_INDEX = 29,
   parameter int SRC_LSB   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              energy_on_i,
   input  logic              an_done_i,
   input  logic              rem_fault_i,
   input  logic              link_up_i,
   input  logic              lp_ack_i,
   input  logic              pd_fault_i,
   input  logic              page_rx_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic              rd_stb_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);

   localparam int SRC_MSB = SRC_LSB + NUM_SRC - 1;
   localparam logic [DATA_W-1:0] SRC_FIELD =
      ((DATA_W'(1) << NUM_SRC) - DATA_W'(1)) << SRC_LSB;
   localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(REG_INDEX);

   if (SRC_MSB >= DATA_W) begin : g_bad_width
      $error("flag field does not fit in DATA_W");
   end
   if (REG_INDEX < 0 || REG_INDEX >= (1 << IDX_W)) begin : g_bad_index
      $error("REG_INDEX not reachable with IDX_W bits");
   end

   logic [NUM_SRC-1:0] raw_sig;
   logic [NUM_SRC-1:0] ev;
   logic [NUM_SRC-1:0] flags;
   logic               rd_hit;
   logic               irq_q;
   logic               unused_mask;

   assign raw_sig = {energy_on_i, an_done_i, rem_fault_i, link_up_i,
                     lp_ack_i, pd_fault_i, page_rx_i};

   assign rd_hit = rd_stb_i && (rd_idx_i == SEL_IDX);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      phy_irq_evdet #(.KIND(src_kind(i))) u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .sig_i   (raw_sig[i]),
         .event_o (ev[i])
      );

      phy_irq_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (ev[i] & mask_i[SRC_LSB+i]),
         .clr_i  (rd_hit),
         .flag_o (flags[i])
      );

      p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !mask_i[SRC_LSB+i] && !flags[i] |=> !flags[i]);
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_hit) rd_data_o[SRC_MSB:SRC_LSB] = flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |flags;
   end

   assign irq_o = irq_q;

   assign unused_mask = ^(mask_i & ~SRC_FIELD);

   p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o & ~SRC_FIELD) == '0);

   p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_i && (rd_idx_i != SEL_IDX) |-> rd_data_o == '0);

   p_irq_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit && (rd_data_o != '0) |=> irq_o);

endmodule

// File: tb/phy_irq_src_latch_test.sv
`timescale 1ns/1ps
module phy_irq_src_latch_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        energy = 1'b0, an_done = 1'b0, rem_fault = 1'b0, link = 1'b0;
   logic        lp_ack = 1'b0, pd_fault = 1'b0, page_rx = 1'b0;
   logic [15:0] mask = '0;
   logic        rd_stb = 1'b0;
   logic [4:0]  rd_idx = '0;
   logic [15:0] rd_data;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   phy_irq_src_latch uut (
      .clk(clk), .rst_n(rst_n),
      .energy_on_i(energy), .an_done_i(an_done), .rem_fault_i(rem_fault),
      .link_up_i(link), .lp_ack_i(lp_ack), .pd_fault_i(pd_fault),
      .page_rx_i(page_rx), .mask_i(mask), .rd_stb_i(rd_stb),
      .rd_idx_i(rd_idx), .rd_data_o(rd_data), .irq_o(irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [4:0] idx, output logic [15:0] val);
      rd_stb = 1'b1;
      rd_idx = idx;
      #1;
      val = rd_data;
      step();
      rd_stb = 1'b0;
   endtask

   task automatic baseline();
      an_done = 0; rem_fault = 0; lp_ack = 0; pd_fault = 0; page_rx = 0;
      energy = 0; link = 1;
   endtask

   // raise the event for register bit b (level inputs take their active edge)
   task automatic fire(input int b);
      case (b)
         1: page_rx = 1;
         2: pd_fault = 1;
         3: lp_ack = 1;
         4: link = 0;
         5: rem_fault = 1;
         6: an_done = 1;
         7: energy = 1;
         default: ;
      endcase
   endtask

   initial begin
      logic [15:0] v;
      logic [15:0] m;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R11 reset state
      chk("R11 irq after reset", {15'd0, irq}, 16'd0);
      rd(5'd29, v);
      chk("R11 flags after reset", v, 16'd0);

      // link rising from reset value is not an event (R4)
      mask = 16'hFFFF;
      baseline();
      step(); step();
      rd(5'd29, v);
      chk("R4 link rise no event", v, 16'd0);

      // single-source sweep: R1 R3 R6 R10
      for (int b = 1; b <= 7; b++) begin
         fire(b);
         step();
         baseline();
         step();
         chk("R10 irq follows flag", {15'd0, irq}, 16'd1);
         rd(5'd29, v);
         chk("R3 bit position", v, 16'd1 << b);
         step();
         chk("R10 irq drops", {15'd0, irq}, 16'd0);
         rd(5'd29, v);
         chk("R6 cleared by read", v, 16'd0);
      end

      // mask sweep, all 128 patterns: R2 R5 R7
      for (int p = 0; p < 128; p++) begin
         m = {8'hA5, 7'(p), 1'b1};
         baseline();
         mask = m;
         for (int b = 1; b <= 7; b++) fire(b);
         step();
         mask = 16'h0000;
         baseline();
         for (int b = 1; b <= 7; b++) fire(b);   // masked events: discarded
         step();
         baseline();
         mask = 16'hFFFF;                          // later unmasking adds nothing
         step();
         chk("R5 irq while held", {15'd0, irq}, {15'd0, p != 0});
         rd(5'd29, v);
         chk("R7 R2 masked pattern", v, {8'h00, 7'(p), 1'b0});
      end

      // R4 level held across a clear does not re-raise; opposite edges ignored
      mask = 16'hFFFF;
      baseline();
      step();
      energy = 1; step(); step();
      rd(5'd29, v);
      chk("R4 energy rise", v, 16'h0080);
      step(); step();
      rd(5'd29, v);
      chk("R4 energy held no refire", v, 16'h0000);
      energy = 0; link = 0; step();
      link = 1; step();
      link = 1; step();
      rd(5'd29, v);
      chk("R4 energy fall/link down then up", v, 16'h0010);

      // R9 other indices return 0 and keep flags
      an_done = 1; step(); an_done = 0; step();
      for (int i = 0; i < 32; i++) begin
         if (i != 29) begin
            rd(5'(i), v);
            chk("R9 other index reads 0", v, 16'h0000);
         end
      end
      rd(5'd29, v);
      chk("R9 flags kept", v, 16'h0040);

      // R8 event in same cycle as clearing read
      rem_fault = 1; step(); rem_fault = 0;
      rd_stb = 1; rd_idx = 5'd29; page_rx = 1;
      #1;
      chk("R8 read returns old", rd_data, 16'h0020);
      step();
      rd_stb = 0; page_rx = 0;
      rd(5'd29, v);
      chk("R8 new event kept", v, 16'h0002);

      // R1 data valid only during strobe
      lp_ack = 1; step(); lp_ack = 0;
      rd_idx = 5'd29; #1;
      chk("R1 no strobe reads 0", rd_data, 16'h0000);
      rd(5'd29, v);
      chk("R1 strobed read", v, 16'h0008);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule